// File: doc/BRIEF.md
# Miss Source History Predictor

This block watches where the cache misses of one partition were served from, and uses that record to set how the next miss is requested. Each completed fill reports two things: its class (instruction or data) and its source (another cache or memory). The block keeps a separate sliding window of the most recent fill sources for each class. For each new miss, it looks at the window of the matching class and makes two choices. The first is between a broadcast peer-to-peer request and a unicast mediated request to the coherence gateway. The second is whether a speculative memory prefetch should go out with that request.

Each window holds one bit per fill. A bit of 1 means the fill came from another cache, and a bit of 0 means it came from memory. Next to each window sits a running count of the 1 bits. The count is adjusted on every shift, from the bit that enters and the bit that leaves, so the block never recounts the whole window. Two programmable thresholds turn these counts into the request mode and the prefetch enable. The lookup outputs depend only on state held at the start of the cycle.

Top module: `miss_src_predictor`

## Requirements
- R1: After reset, both windows hold only memory entries (all bits 0), the peer threshold is 32 and the prefetch threshold is 40. A lookup of either class therefore returns mediated mode (`lkp_p2p_o`=0) with prefetch enabled (`lkp_pf_en_o`=1).
- R2: A fill with `fill_valid_i`=1 shifts one bit into the window of its class: 1 when `fill_from_cache_i`=1, 0 otherwise. The oldest of the 64 bits is dropped, so the decision reflects only the last 64 fills of that class.
- R3: The class inputs use 1 for instruction and 0 for data. A fill changes only the window of its own class, and a lookup reads only the window of its own class.
- R4: `lkp_p2p_o` is 1 when the count of cache-sourced entries in the looked-up window is at or above the peer threshold, and 0 otherwise.
- R5: `lkp_pf_en_o` is 1 when the count of memory-sourced entries (64 minus the cache count) is at or above the prefetch threshold, and 0 otherwise.
- R6: A lookup in the same cycle as a fill or a threshold write sees the state from before that update. The update takes effect from the next cycle.
- R7: When `cfg_we_i`=1, `cfg_data_i` is written to the peer threshold if `cfg_sel_i`=0, or to the prefetch threshold if `cfg_sel_i`=1. The other threshold keeps its value.
- R8: While `lkp_valid_i`=0, both `lkp_p2p_o` and `lkp_pf_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | A fill completed this cycle |
| fill_is_code_i | input | 1 | Fill class: 1 = instruction, 0 = data |
| fill_from_cache_i | input | 1 | Fill source: 1 = another cache, 0 = memory |
| lkp_valid_i | input | 1 | A new miss asks for a decision |
| lkp_is_code_i | input | 1 | Lookup class: 1 = instruction, 0 = data |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_sel_i | input | 1 | Threshold to write: 0 = peer, 1 = prefetch |
| cfg_data_i | input | 7 | New threshold value |
| lkp_p2p_o | output | 1 | 1 = peer-to-peer broadcast, 0 = mediated unicast |
| lkp_pf_en_o | output | 1 | 1 = send a speculative memory prefetch |

## Verification
The bench builds the block with its default parameters: a 64-entry window, a 7-bit count, and reset thresholds of 32 and 40. With these values, a run of cache fills crosses both decision points within a few dozen cycles. A further 64 fills push every entry out of the window, so the drop of the oldest bit and the return to all-memory can be checked directly. Because the threshold field is 7 bits wide, the bench can also write 0, which makes the output always true, and 127, which is above any reachable count and so makes the output always false.

// File: rtl/msp_pkg.sv
package msp_pkg;
  typedef enum logic {
    CLS_DATA = 1'b0,
    CLS_CODE = 1'b1
  } fill_cls_e;

  typedef enum logic {
    THR_P2P = 1'b0,
    THR_PF  = 1'b1
  } thr_sel_e;
endpackage

// File: rtl/msp_history.sv
module msp_history #(
  parameter int HIST_LEN = 64,
  localparam int CNT_W = $clog2(HIST_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] c2c_cnt_o
);
  logic [HIST_LEN-1:0] hist_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                old_bit;

  assign old_bit = hist_q[HIST_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (push_i) begin
      hist_q <= {hist_q[HIST_LEN-2:0], bit_i};
      // incremental update from the entering and leaving bits
      cnt_q  <= cnt_q + {{(CNT_W-1){1'b0}}, bit_i} - {{(CNT_W-1){1'b0}}, old_bit};
    end
  end

  assign c2c_cnt_o = cnt_q;

  assert_cnt_matches_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) == $countones(hist_q));
  assert_cnt_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= HIST_LEN);
  assert_hold_without_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(hist_q));
endmodule

// File: rtl/msp_thresholds.sv
module msp_thresholds #(
  parameter int CNT_W       = 7,
  parameter int P2P_THR_RST = 32,
  parameter int PF_THR_RST  = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] p2p_thr_o,
  output logic [CNT_W-1:0] pf_thr_o
);
  import msp_pkg::*;

  logic [CNT_W-1:0] p2p_q, pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p2p_q <= CNT_W'(P2P_THR_RST);
      pf_q  <= CNT_W'(PF_THR_RST);
    end else if (we_i) begin
      if (thr_sel_e'(sel_i) == THR_P2P) p2p_q <= data_i;
      else                              pf_q  <= data_i;
    end
  end

  assign p2p_thr_o = p2p_q;
  assign pf_thr_o  = pf_q;

  assert_p2p_thr_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !sel_i) |=> $stable(p2p_q));
  assert_pf_thr_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i) |=> $stable(pf_q));
endmodule

// File: rtl/msp_decide.sv
module msp_decide #(
  parameter int HIST_LEN = 64,
  parameter int CNT_W    = 7
) (
  input  logic             valid_i,
  input  logic [CNT_W-1:0] c2c_cnt_i,
  input  logic [CNT_W-1:0] p2p_thr_i,
  input  logic [CNT_W-1:0] pf_thr_i,
  output logic             p2p_o,
  output logic             pf_en_o
);
  logic [CNT_W-1:0] mem_cnt;

  always_comb begin
    mem_cnt = CNT_W'(HIST_LEN) - c2c_cnt_i;
    p2p_o   = valid_i && (c2c_cnt_i >= p2p_thr_i);
    pf_en_o = valid_i && (mem_cnt >= pf_thr_i);
  end
endmodule

// File: rtl/miss_src_predictor.sv
module miss_src_predictor #(
  parameter int HIST_LEN    = 64,
  parameter int P2P_THR_RST = 32,
  parameter int PF_THR_RST  = 40,
  localparam int CNT_W      = $clog2(HIST_LEN + 1),
  localparam int N_CLS      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_valid_i,
  input  logic             fill_is_code_i,
  input  logic             fill_from_cache_i,
  input  logic             lkp_valid_i,
  input  logic             lkp_is_code_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [CNT_W-1:0] cfg_data_i,
  output logic             lkp_p2p_o,
  output logic             lkp_pf_en_o
);
  import msp_pkg::*;

  logic [CNT_W-1:0] c2c_cnt [N_CLS];
  logic [CNT_W-1:0] p2p_thr, pf_thr, sel_cnt;

  for (genvar g = 0; g < N_CLS; g++) begin : g_cls
    msp_history #(.HIST_LEN(HIST_LEN)) u_hist (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (fill_valid_i && (fill_is_code_i == g[0])),
      .bit_i     (fill_from_cache_i),
      .c2c_cnt_o (c2c_cnt[g])
    );
  end

  msp_thresholds #(
    .CNT_W(CNT_W), .P2P_THR_RST(P2P_THR_RST), .PF_THR_RST(PF_THR_RST)
  ) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .data_i    (cfg_data_i),
    .p2p_thr_o (p2p_thr),
    .pf_thr_o  (pf_thr)
  );

  assign sel_cnt = (fill_cls_e'(lkp_is_code_i) == CLS_CODE) ? c2c_cnt[1] : c2c_cnt[0];

  msp_decide #(.HIST_LEN(HIST_LEN), .CNT_W(CNT_W)) u_dec (
    .valid_i   (lkp_valid_i),
    .c2c_cnt_i (sel_cnt),
    .p2p_thr_i (p2p_thr),
    .pf_thr_i  (pf_thr),
    .p2p_o     (lkp_p2p_o),
    .pf_en_o   (lkp_pf_en_o)
  );

  assert_idle_outputs_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> !lkp_p2p_o && !lkp_pf_en_o);
  assert_data_fill_keeps_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_i && fill_is_code_i) |=> $stable(c2c_cnt[1]));
  assert_code_fill_keeps_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_i && !fill_is_code_i) |=> $stable(c2c_cnt[0]));
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && fill_from_cache_i && !fill_is_code_i |=>
      c2c_cnt[0] >= $past(c2c_cnt[0]));
endmodule

// File: tb/miss_src_predictor_tb_top.sv
module miss_src_predictor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HL = 64;
  localparam int MAX_CYC = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_v = 0, fill_code = 0, fill_c2c = 0;
  logic lkp_v = 0, lkp_code = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [6:0] cfg_d = '0;
  logic p2p, pf;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  bit hist_q [2][$];
  int thr_p2p = 32, thr_pf = 40;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_src_predictor dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_v), .fill_is_code_i(fill_code), .fill_from_cache_i(fill_c2c),
    .lkp_valid_i(lkp_v), .lkp_is_code_i(lkp_code),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_d),
    .lkp_p2p_o(p2p), .lkp_pf_en_o(pf)
  );

  function automatic int ones(int c);
    int s = 0;
    foreach (hist_q[c][i]) s += int'(hist_q[c][i]);
    return s;
  endfunction

  // one cycle: drive at negedge, compare shortly after, update model at posedge
  task automatic step(input string tag, input bit fv, input bit fc, input bit fsrc,
                      input bit lv, input bit lc, input bit we, input bit ws, input int wd);
    int c, exp_p2p, exp_pf;
    @(negedge clk);
    fill_v = fv; fill_code = fc; fill_c2c = fsrc;
    lkp_v = lv; lkp_code = lc; cfg_we = we; cfg_sel = ws; cfg_d = 7'(wd);
    #1;
    c = ones(int'(lc));
    exp_p2p = (lv && c >= thr_p2p) ? 1 : 0;
    exp_pf  = (lv && (HL - c) >= thr_pf) ? 1 : 0;
    n_cmp++;
    if (int'(p2p) != exp_p2p || int'(pf) != exp_pf) begin
      n_bad++;
      $display("FAIL %s cyc=%0d p2p/pf actual=%0b%0b expected=%0d%0d",
               tag, cyc, p2p, pf, exp_p2p, exp_pf);
    end
    @(posedge clk);
    if (fv) begin
      hist_q[int'(fc)].push_back(fsrc);
      void'(hist_q[int'(fc)].pop_front());
    end
    if (we) begin
      if (ws) thr_pf = wd; else thr_p2p = wd;
    end
  endtask

  initial begin
    for (int k = 0; k < HL; k++) begin
      hist_q[0].push_back(1'b0);
      hist_q[1].push_back(1'b0);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state for both classes; R8: idle outputs
    step("R1", 0,0,0, 1,0, 0,0,0);
    step("R1", 0,0,0, 1,1, 0,0,0);
    step("R8", 0,0,0, 0,0, 0,0,0);
    // R4 R5: data cache fills cross both decision points; R3: code unaffected
    for (int k = 0; k < 40; k++) begin
      step("R4", 1,0,1, 1,0, 0,0,0);
      step("R3", 0,0,0, 1,1, 0,0,0);
    end
    // R6: fill with lookup in the same cycle sees the old count
    step("R6", 1,0,1, 1,0, 0,0,0);
    // R2: 64 memory fills flush the data window
    for (int k = 0; k < HL; k++) step("R2", 1,0,0, 1,0, 0,0,0);
    // R3: code window built up on its own
    for (int k = 0; k < 34; k++) step("R3", 1,1,1, 1,1, 0,0,0);
    step("R3", 0,0,0, 1,0, 0,0,0);
    // R7: threshold writes, same-cycle lookup sees old value (R6)
    step("R6", 0,0,0, 1,0, 1,0,0);
    step("R7", 0,0,0, 1,0, 0,0,0);
    step("R7", 0,0,0, 1,0, 1,1,127);
    step("R5", 0,0,0, 1,0, 0,0,0);
    step("R7", 0,0,0, 1,1, 1,0,127);
    step("R4", 0,0,0, 1,1, 1,1,0);
    step("R5", 0,0,0, 1,1, 0,0,0);
    step("R7", 0,0,0, 1,0, 1,0,20);
    step("R7", 0,0,0, 1,0, 1,1,30);
    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom;
      step("R2", r[0], r[1], r[2] | r[3], r[4], r[5], (r[15:8] == 0), r[6], int'(r[22:16]) % 70);
    end
    step("R8", 1,0,1, 0,1, 0,0,0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      n_bad++;
      $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule